// File: doc/BRIEF.md
# Cascaded-Cell Fault Locator with Bypass

This block watches one phase leg of a cascaded full-bridge converter built from five series cells. It takes the sampled magnitude of the phase output voltage and decides whether a cell has failed. When that voltage stays below a programmable trip level for long enough, the block finds the failed cell without any per-cell voltage sensing. It uses only the two gate commands of every cell and the nominal cell voltage.

For each candidate cell, the block predicts the phase voltage that would appear if that cell alone had dropped out. It then compares every prediction with the measured voltage and names the closest one as the failed cell. A one-hot bypass enable for that cell is latched, so the leg keeps running on the remaining cells. The enable holds until a clear input is pulsed. The candidate comparison runs one cell per clock. With any realistic clock rate, detection, location and bypass finish far inside a 300 ms budget; the programmable hold time dominates the total.

Top module: `cell_fault_locator`

## Requirements
- R1: After reset, `fault_flag` is 0, `bypass_en` is all zeros and `fault_cell` is 0.
- R2: A cell's level is +1 when its gate pair (`gate_hi[c]`,`gate_lo[c]`) is (1,0), −1 when it is (0,1), and 0 when both bits are equal. The prediction for cell i is `v_cell_nom` times the sum of the levels of every cell except i.
- R3: The located cell is the one whose prediction has the smallest absolute difference from `v_meas`. On a tie, the lowest cell index wins.
- R4: A sample counts as a sag only when `v_meas` is strictly below `v_thresh` (signed compare). A sample equal to the threshold never trips the block.
- R5: The block trips only after `hold_cycles`+1 consecutive sag samples. A sag that ends earlier leaves every output unchanged and restarts the count.
- R6: Gate commands and voltages are captured on the trip clock. The outputs change exactly 6 clock edges after the trip, which is `hold_cycles`+7 edges after the first sag sample.
- R7: On location, exactly one bit of `bypass_en` is set (bit c for cell c), `fault_cell` holds c and `fault_flag` is 1. All three hold unchanged until `clr`.
- R8: While any bypass bit is set, further sags do not change any output.
- R9: A one-cycle `clr` returns all outputs to the reset state and restarts sag timing, after which a new fault is located normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_hi | input | 5 | Upper switch command per cell, bit c for cell c |
| gate_lo | input | 5 | Lower switch command per cell, bit c for cell c |
| v_meas | input | 16 | Signed measured phase output magnitude |
| v_cell_nom | input | 16 | Signed nominal voltage of one cell |
| v_thresh | input | 16 | Signed trip level |
| hold_cycles | input | 24 | Extra consecutive sag samples required before tripping |
| clr | input | 1 | Releases the latched bypass and fault state |
| fault_flag | output | 1 | High while a cell is bypassed |
| fault_cell | output | 3 | Index of the bypassed cell |
| bypass_en | output | 5 | One-hot bypass enable, bit c for cell c |

## Verification
Every cycle, the assertions hold the following properties:
- at most one bypass bit is set, and `fault_flag` agrees with it;
- a latched bypass never changes without `clr`;
- the scan index stays within range;
- no scan runs while a cell is bypassed;
- a trip with a nonzero hold is always preceded by a sag sample.

The checks that depend on stored values can only be shown by the bench's scenarios. These are the arithmetic of the predictions, the choice of the closest one, the lowest-index rule on ties, the exact trip latency for several hold values, and the rejection of a sag one sample too short.

// File: rtl/cf_pkg.sv
package cf_pkg;

   // Signed level of one full-bridge cell from its two gate commands.
   function automatic logic signed [1:0] cell_level(input logic hi, input logic lo);
      if (hi && !lo)      return 2'sd1;
      else if (!hi && lo) return -2'sd1;
      else                return 2'sd0;
   endfunction

endpackage

// File: rtl/cf_sag_timer.sv
module cf_sag_timer #(
   parameter int VW = 16,
   parameter int DW = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [VW-1:0] v_meas,
   input  logic signed [VW-1:0] v_thresh,
   input  logic [DW-1:0]        hold,
   output logic                 trip
);
   logic          under;
   logic [DW-1:0] run_q;

   assign under = (v_meas < v_thresh);
   assign trip  = en && under && (run_q >= hold);

   always_ff @(posedge clk) begin
      if (!rst_n || !en || !under) run_q <= '0;
      else if (run_q != {DW{1'b1}}) run_q <= run_q + 1'b1;
   end

   // R5: a trip with a nonzero hold needs a sag sample on the previous clock
   a_r5_sag_precedes: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && hold != '0) |-> $past(under));
   // R4: no trip on a sample at or above the threshold
   a_r4_strict_below: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> (v_meas < v_thresh));
endmodule

// File: rtl/cf_predict.sv
module cf_predict import cf_pkg::*; #(
   parameter int N_CELLS = 5,
   parameter int VW      = 16,
   parameter int EW      = 20,
   parameter int IW      = 3
) (
   input  logic [N_CELLS-1:0]   hi,
   input  logic [N_CELLS-1:0]   lo,
   input  logic [IW-1:0]        sel,
   input  logic signed [VW-1:0] v_nom,
   input  logic signed [VW-1:0] v_meas,
   output logic [EW-1:0]        err
);
   logic signed [EW-1:0] nom_x, meas_x, acc, diff;

   assign nom_x  = {{(EW-VW){v_nom[VW-1]}},  v_nom};
   assign meas_x = {{(EW-VW){v_meas[VW-1]}}, v_meas};

   always_comb begin
      acc = '0;
      for (int j = 0; j < N_CELLS; j++) begin
         if (IW'(j) != sel) begin
            case (cell_level(hi[j], lo[j]))
               2'sd1:   acc = acc + nom_x;
               -2'sd1:  acc = acc - nom_x;
               default: acc = acc;
            endcase
         end
      end
      diff = meas_x - acc;
      err  = (diff < 0) ? EW'(-diff) : EW'(diff);
   end
endmodule

// File: rtl/cf_argmin_scan.sv
module cf_argmin_scan #(
   parameter int N_CELLS = 5,
   parameter int EW      = 20,
   parameter int IW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start,
   input  logic [EW-1:0] err,
   output logic [IW-1:0] sel,
   output logic          busy,
   output logic          done,
   output logic [IW-1:0] win
);
   localparam logic [IW-1:0] LAST = IW'(N_CELLS - 1);

   logic [EW-1:0] best_q;
   logic          take;

   // strict less-than keeps the earlier index on equal errors
   assign take = (sel == '0) || (err < best_q);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         sel    <= '0;
         best_q <= '0;
         win    <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               sel  <= '0;
            end
         end else begin
            if (take) begin
               best_q <= err;
               win    <= sel;
            end
            if (sel == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               sel <= sel + 1'b1;
            end
         end
      end
   end

   a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sel <= LAST));
   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel == LAST && !clr) |=> done);
endmodule

// File: rtl/cell_fault_locator.sv
module cell_fault_locator import cf_pkg::*; #(
   parameter int N_CELLS = 5,
   parameter int VW      = 16,
   parameter int DW      = 24
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_CELLS-1:0]                gate_hi,
   input  logic [N_CELLS-1:0]                gate_lo,
   input  logic signed [VW-1:0]              v_meas,
   input  logic signed [VW-1:0]              v_cell_nom,
   input  logic signed [VW-1:0]              v_thresh,
   input  logic [DW-1:0]                     hold_cycles,
   input  logic                              clr,
   output logic                              fault_flag,
   output logic [((N_CELLS>1)?$clog2(N_CELLS):1)-1:0] fault_cell,
   output logic [N_CELLS-1:0]                bypass_en
);
   localparam int IW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
   localparam int EW = VW + $clog2(N_CELLS + 1) + 1;

   generate
      if (N_CELLS < 2 || N_CELLS > 64) begin : g_bad_cells
         $error("N_CELLS out of range");
      end
      if (VW < 4 || DW < 1) begin : g_bad_width
         $error("VW or DW too small");
      end
   endgenerate

   logic                 locked, trip, busy, done;
   logic [IW-1:0]        sel, win;
   logic [EW-1:0]        err;
   logic [N_CELLS-1:0]   snap_hi, snap_lo, hit;
   logic signed [VW-1:0] snap_meas, snap_nom;

   assign locked = |bypass_en;

   cf_sag_timer #(.VW(VW), .DW(DW)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(!locked && !busy && !done && !clr),
      .v_meas(v_meas), .v_thresh(v_thresh), .hold(hold_cycles), .trip(trip));

   // freeze the operating point seen at the trip clock
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_hi   <= '0;
         snap_lo   <= '0;
         snap_meas <= '0;
         snap_nom  <= '0;
      end else if (trip) begin
         snap_hi   <= gate_hi;
         snap_lo   <= gate_lo;
         snap_meas <= v_meas;
         snap_nom  <= v_cell_nom;
      end
   end

   cf_predict #(.N_CELLS(N_CELLS), .VW(VW), .EW(EW), .IW(IW)) u_pred (
      .hi(snap_hi), .lo(snap_lo), .sel(sel), .v_nom(snap_nom),
      .v_meas(snap_meas), .err(err));

   cf_argmin_scan #(.N_CELLS(N_CELLS), .EW(EW), .IW(IW)) u_scan (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(trip), .err(err),
      .sel(sel), .busy(busy), .done(done), .win(win));

   genvar c;
   generate
      for (c = 0; c < N_CELLS; c++) begin : g_hit
         assign hit[c] = done && (win == IW'(c));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         bypass_en  <= '0;
         fault_flag <= 1'b0;
         fault_cell <= '0;
      end else if (done && !locked) begin
         bypass_en  <= hit;
         fault_flag <= 1'b1;
         fault_cell <= win;
      end
   end

   a_r7_one_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bypass_en));
   a_r7_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag == (bypass_en != '0));
   a_r7_bypass_held: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !clr) |=> $stable(bypass_en) && $stable(fault_cell));
   a_r8_no_scan_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !busy);
   a_r9_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (bypass_en == '0) && !fault_flag);
endmodule

// File: tb/sim_cell_fault_locator.sv
`timescale 1ns/1ps
module sim_cell_fault_locator;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        gate_hi = '0, gate_lo = '0;
   logic signed [15:0] v_meas = 16'sd5000, v_cell_nom = 16'sd1000, v_thresh = 16'sd4250;
   logic [23:0]       hold_cycles = '0;
   logic              clr = 1'b0;
   logic              fault_flag;
   logic [2:0]        fault_cell;
   logic [4:0]        bypass_en;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cell_fault_locator u0 (
      .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
      .v_meas(v_meas), .v_cell_nom(v_cell_nom), .v_thresh(v_thresh),
      .hold_cycles(hold_cycles), .clr(clr), .fault_flag(fault_flag),
      .fault_cell(fault_cell), .bypass_en(bypass_en));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk); v_meas = 16'sd5000; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(fault_flag == 0, "R1", "flag after reset", fault_flag, 0);
      chk(bypass_en == 0, "R1", "bypass after reset", bypass_en, 0);
      chk(fault_cell == 0, "R1", "cell after reset", fault_cell, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive a sustained sag and check latency, located cell and outputs
   task automatic t_locate(input logic [4:0] hi, input logic [4:0] lo, input int meas,
                           input int exp_cell, input int hold, input string req);
      int edges = 0;
      @(negedge clk);
      gate_hi = hi; gate_lo = lo; hold_cycles = 24'(hold); v_meas = 16'sd5000;
      @(negedge clk);
      v_meas = 16'(meas);
      while (!fault_flag && edges < hold + 40) begin
         @(posedge clk); edges++;
         @(negedge clk);
      end
      chk(edges == hold + 7, "R6", "edges to bypass", edges, hold + 7);
      chk(fault_cell == 3'(exp_cell), req, "located cell", fault_cell, exp_cell);
      chk(bypass_en == 5'(1 << exp_cell), "R7", "bypass pattern", bypass_en, 1 << exp_cell);
      chk(fault_flag == 1, "R7", "flag set", fault_flag, 1);
   endtask

   // R5: sag exactly hold samples long must not trip
   task automatic t_short_sag();
      @(negedge clk); hold_cycles = 24'd10; gate_hi = 5'b10111; gate_lo = 5'b01100;
      v_meas = 16'sd2900;
      repeat (10) @(negedge clk);
      v_meas = 16'sd5000;
      repeat (20) @(negedge clk);
      chk(fault_flag == 0, "R5", "flag after short sag", fault_flag, 0);
      chk(bypass_en == 0, "R5", "bypass after short sag", bypass_en, 0);
   endtask

   // R4: a sample equal to the threshold is not a sag
   task automatic t_equal_threshold();
      @(negedge clk); hold_cycles = 24'd0; v_meas = v_thresh;
      repeat (30) @(negedge clk);
      chk(fault_flag == 0, "R4", "flag at threshold", fault_flag, 0);
      chk(bypass_en == 0, "R4", "bypass at threshold", bypass_en, 0);
      v_meas = 16'sd5000;
   endtask

   // R8: a new sag pointing to another cell is ignored while bypassed
   task automatic t_locked_ignores();
      @(negedge clk); gate_hi = 5'b01111; gate_lo = 5'b10000; hold_cycles = 24'd0;
      v_meas = 16'sd3990;
      repeat (40) @(negedge clk);
      chk(fault_cell == 3'd3, "R8", "cell while bypassed", fault_cell, 3);
      chk(bypass_en == 5'b01000, "R8", "bypass while bypassed", bypass_en, 8);
   endtask

   task automatic t_clear();
      pulse_clr();
      chk(fault_flag == 0, "R9", "flag after clr", fault_flag, 0);
      chk(bypass_en == 0, "R9", "bypass after clr", bypass_en, 0);
      chk(fault_cell == 0, "R9", "cell after clr", fault_cell, 0);
   endtask

   initial begin
      t_reset();
      // R2/R3: levels +1,+1,0(1,1),-1,+1 -> predictions 1000,1000,2000,3000,1000
      t_locate(5'b10111, 5'b01100, 2900, 3, 0, "R2");
      t_locked_ignores();
      t_clear();
      // R3: last cell, levels +1,+1,+1,+1,-1 -> 2000 x4, 4000
      t_locate(5'b01111, 5'b10000, 3990, 4, 25, "R3");
      pulse_clr();
      // R3 tie: levels 0,+1,+1,+1,+1 -> 4000,3000,3000,3000,3000, lowest index 1
      t_locate(5'b11110, 5'b00000, 3050, 1, 3, "R3");
      pulse_clr();
      // R3 tie across all cells: all +1, every prediction 4000 -> cell 0
      t_locate(5'b11111, 5'b00000, 4100, 0, 1, "R3");
      pulse_clr();
      t_short_sag();
      t_equal_threshold();
      // R9: after clearing, a fresh fault is located normally
      t_locate(5'b10111, 5'b01100, 2900, 3, 2, "R9");
      pulse_clr();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule